// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the six status flags of a UART-style serial port and produces that port's single interrupt request. The transmit and receive datapaths report their events to it as one-cycle strobes: a byte moving from the transmit holding register into the shift register, the end of a frame that carried data, a received character landing in the receive holding register, an idle line, a line break, and the raw clear-to-send pin itself. The register bus reports its accesses as strobes too: a write to the transmit data register, a read of the receive data register, a write to a write-one-to-clear register, and a write to a command register that can flush either direction.

Every flag is a registered bit that moves one clock after its strobe. A set event outranks a clear in the same cycle, so no hardware event is lost to a software clear. The idle flag carries a re-arm latch: after it fires it stays quiet until a fresh character has arrived. The interrupt line is the OR of the flags masked by a per-flag enable vector.

Top module: `sfc_status_ctrl`

## Requirements
- R1: The flag vector has bit 0 = clear-to-send change, bit 1 = line break, bit 2 = transmit buffer empty, bit 3 = transmission complete, bit 4 = receive not empty, bit 5 = idle line. During and after reset it reads 6'b001100, and the idle re-arm latch is armed.
- R2: The clear-to-send pin passes through SYNC_STAGES flops before edge detection. A level change sampled at clock edge t sets bit 0 at edge t+SYNC_STAGES. No change is reported within the first SYNC_STAGES+1 edges after reset, whatever the pin level. Bit 0 clears when bit 0 of the clear word is written as 1.
- R3: A break strobe sets bit 1, and bit 1 of the clear word clears it. With HAS_BREAK = 0, bit 1 always reads 0.
- R4: Bit 2 sets on a transmit-load strobe or on a command write with command bit 0 (transmit flush) at 1. A transmit data write clears it.
- R5: A frame-done strobe sets bit 3 only if bit 2 is already 1 in that cycle. Bit 3 of the clear word clears it.
- R6: A received-character strobe sets bit 4. A receive data read, or a command write with command bit 1 (receive flush) at 1, clears it.
- R7: An idle strobe sets bit 5 only while the re-arm latch is armed. Setting bit 5 disarms the latch, and a received-character strobe re-arms it. Bit 5 of the clear word clears bit 5.
- R8: When a set event and a clear strobe reach the same flag in one cycle, the flag ends up 1.
- R9: Bits written as 0 in the clear word leave their flags unchanged.
- R10: The interrupt output is 1 exactly when some flag and its enable bit are both 1. It follows the flag register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_in | input | 1 | Raw clear-to-send pin |
| ev_tx_load | input | 1 | Transmit holding data moved into the shift register |
| ev_tx_frame_done | input | 1 | A frame carrying data finished shifting out |
| ev_rx_char | input | 1 | Received character moved into the receive holding register |
| ev_idle | input | 1 | Idle line detected |
| ev_break | input | 1 | Line break detected |
| wr_tdata | input | 1 | Bus write to the transmit data register |
| rd_rdata | input | 1 | Bus read of the receive data register |
| wr_clr | input | 1 | Bus write to the clear register |
| clr_data | input | 6 | Clear word; a 1 clears the flag at the same position |
| wr_cmd | input | 1 | Bus write to the command register |
| cmd_data | input | 2 | Command word: bit 0 transmit flush, bit 1 receive flush |
| irq_en | input | 6 | Per-flag interrupt enables |
| flags | output | 6 | Flag vector |
| irq | output | 1 | Combined interrupt request |

## Verification
The overlaps that matter most are a hardware set event and a software clear on the same flag in the same cycle, and an idle detection coinciding with a received character, which disarms and re-arms the idle latch at once. Directed steps pair a received-character strobe with a data read, a break with its clear bit, and a transmit load with a data write, and expect the flag to read 1 afterwards. A long stretch of sparse random strobes then makes these and other overlaps happen freely. On every clock a behavioural reference model, which keeps the clear-to-send history in a queue, judges each flag bit and the interrupt line.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   localparam int FLAG_W = 6;
   localparam int F_CTS  = 0;
   localparam int F_BRK  = 1;
   localparam int F_TXE  = 2;
   localparam int F_TC   = 3;
   localparam int F_RXNE = 4;
   localparam int F_IDLE = 5;
   localparam int CMD_W  = 2;
   localparam int C_TXFL = 0;
   localparam int C_RXFL = 1;

   typedef logic [FLAG_W-1:0] flag_vec_t;

   localparam flag_vec_t FLAG_RST = flag_vec_t'((1 << F_TXE) | (1 << F_TC));
endpackage

// File: rtl/sfc_flag_cell.sv
module sfc_flag_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/sfc_cts_edge.sv
module sfc_cts_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic change_o
);
   localparam int CNT_W = $clog2(SYNC_STAGES + 2);
   localparam logic [CNT_W-1:0] WARM = CNT_W'(SYNC_STAGES + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("sfc_cts_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sh_q;
   logic                   prev_q;
   logic [CNT_W-1:0]       warm_q;
   logic                   armed;

   assign armed = (warm_q == WARM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
         warm_q <= '0;
      end else begin
         sh_q   <= {sh_q[SYNC_STAGES-2:0], async_i};
         prev_q <= sh_q[SYNC_STAGES-1];
         if (!armed) warm_q <= warm_q + CNT_W'(1);
      end
   end

   assign change_o = armed & (sh_q[SYNC_STAGES-1] ^ prev_q);
endmodule

// File: rtl/sfc_irq_merge.sv
module sfc_irq_merge #(
   parameter int W = 6
) (
   input  logic [W-1:0] flags_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   generate
      if (W < 1) begin : g_bad_width
         $error("sfc_irq_merge: W must be positive");
      end
   endgenerate

   assign irq_o = |(flags_i & en_i);
endmodule

// File: rtl/sfc_status_ctrl.sv
module sfc_status_ctrl
   import sfc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_BREAK   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cts_in,
   input  logic              ev_tx_load,
   input  logic              ev_tx_frame_done,
   input  logic              ev_rx_char,
   input  logic              ev_idle,
   input  logic              ev_break,
   input  logic              wr_tdata,
   input  logic              rd_rdata,
   input  logic              wr_clr,
   input  logic [FLAG_W-1:0] clr_data,
   input  logic              wr_cmd,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic [FLAG_W-1:0] irq_en,
   output logic [FLAG_W-1:0] flags,
   output logic              irq
);
   flag_vec_t set_vec;
   flag_vec_t clr_vec;
   flag_vec_t w1c;
   logic      cts_change;
   logic      idle_armed_q;
   logic      idle_fire;

   sfc_cts_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_i  (cts_in),
      .change_o (cts_change)
   );

   assign w1c       = wr_clr ? clr_data : '0;
   assign idle_fire = ev_idle & idle_armed_q;

   always_comb begin
      set_vec         = '0;
      clr_vec         = '0;
      set_vec[F_CTS]  = cts_change;
      clr_vec[F_CTS]  = w1c[F_CTS];
      set_vec[F_BRK]  = ev_break;
      clr_vec[F_BRK]  = w1c[F_BRK];
      set_vec[F_TXE]  = ev_tx_load | (wr_cmd & cmd_data[C_TXFL]);
      clr_vec[F_TXE]  = wr_tdata;
      set_vec[F_TC]   = ev_tx_frame_done & flags[F_TXE];
      clr_vec[F_TC]   = w1c[F_TC];
      set_vec[F_RXNE] = ev_rx_char;
      clr_vec[F_RXNE] = rd_rdata | (wr_cmd & cmd_data[C_RXFL]);
      set_vec[F_IDLE] = idle_fire;
      clr_vec[F_IDLE] = w1c[F_IDLE];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          idle_armed_q <= 1'b1;
      else if (ev_rx_char) idle_armed_q <= 1'b1;
      else if (idle_fire)  idle_armed_q <= 1'b0;
   end

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
         if (i == F_BRK && !HAS_BREAK) begin : g_absent
            assign flags[i] = 1'b0;
         end else begin : g_cell
            sfc_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (set_vec[i]),
               .clr_i (clr_vec[i]),
               .q_o   (flags[i])
            );
         end
      end
   endgenerate

   sfc_irq_merge #(.W(FLAG_W)) u_irq (
      .flags_i (flags),
      .en_i    (irq_en),
      .irq_o   (irq)
   );
endmodule

// File: rtl/sfc_status_chk.sv
module sfc_status_chk
   import sfc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_BREAK   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_tx_load,
   input logic              ev_tx_frame_done,
   input logic              ev_rx_char,
   input logic              ev_idle,
   input logic              ev_break,
   input logic              wr_tdata,
   input logic              wr_clr,
   input logic [FLAG_W-1:0] clr_data,
   input logic              wr_cmd,
   input logic [CMD_W-1:0]  cmd_data,
   input logic [FLAG_W-1:0] irq_en,
   input logic [FLAG_W-1:0] flags,
   input logic              irq
);
   int unsigned edges_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            edges_q <= 0;
      else if (edges_q < 64) edges_q <= edges_q + 1;
   end

   AST_CTS_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_q <= SYNC_STAGES + 1) |-> !flags[F_CTS]); // R2

   AST_BRK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_BREAK && ev_break) |=> flags[F_BRK]); // R3

   AST_TXE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tdata && !ev_tx_load && !(wr_cmd && cmd_data[C_TXFL])) |=> !flags[F_TXE]); // R4

   AST_TC_NEEDS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[F_TC]) |-> $past(flags[F_TXE])); // R5

   AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_char |=> flags[F_RXNE]); // R8

   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && clr_data[F_IDLE] && !ev_idle) |=> !flags[F_IDLE]); // R7

   AST_ZERO_CLR_KEEPS_TC: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[F_TC] && !(wr_clr && clr_data[F_TC])) |=> flags[F_TC]); // R9

   AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & irq_en) == '0) |-> !irq); // R10

   AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & irq_en) != '0) |-> irq); // R10
endmodule

bind sfc_status_ctrl sfc_status_chk #(
   .SYNC_STAGES (SYNC_STAGES),
   .HAS_BREAK   (HAS_BREAK)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .ev_tx_load       (ev_tx_load),
   .ev_tx_frame_done (ev_tx_frame_done),
   .ev_rx_char       (ev_rx_char),
   .ev_idle          (ev_idle),
   .ev_break         (ev_break),
   .wr_tdata         (wr_tdata),
   .wr_clr           (wr_clr),
   .clr_data         (clr_data),
   .wr_cmd           (wr_cmd),
   .cmd_data         (cmd_data),
   .irq_en           (irq_en),
   .flags            (flags),
   .irq              (irq)
);

// File: tb/sfc_status_ctrl_tb.sv
module sfc_status_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cts_in = 1'b1;
   logic       ev_tx_load = 0, ev_tx_frame_done = 0, ev_rx_char = 0, ev_idle = 0, ev_break = 0;
   logic       wr_tdata = 0, rd_rdata = 0, wr_clr = 0, wr_cmd = 0;
   logic [5:0] clr_data = '0;
   logic [1:0] cmd_data = '0;
   logic [5:0] irq_en = '0;
   logic [5:0] flags, flags_nb;
   logic       irq, irq_nb;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sfc_status_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .ev_tx_load(ev_tx_load),
      .ev_tx_frame_done(ev_tx_frame_done), .ev_rx_char(ev_rx_char), .ev_idle(ev_idle),
      .ev_break(ev_break), .wr_tdata(wr_tdata), .rd_rdata(rd_rdata), .wr_clr(wr_clr),
      .clr_data(clr_data), .wr_cmd(wr_cmd), .cmd_data(cmd_data), .irq_en(irq_en),
      .flags(flags), .irq(irq));

   sfc_status_ctrl #(.HAS_BREAK(1'b0)) u_dut_nb (
      .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .ev_tx_load(ev_tx_load),
      .ev_tx_frame_done(ev_tx_frame_done), .ev_rx_char(ev_rx_char), .ev_idle(ev_idle),
      .ev_break(ev_break), .wr_tdata(wr_tdata), .rd_rdata(rd_rdata), .wr_clr(wr_clr),
      .clr_data(clr_data), .wr_cmd(wr_cmd), .cmd_data(cmd_data), .irq_en(irq_en),
      .flags(flags_nb), .irq(irq_nb));

   // behavioural reference model
   logic [5:0] m_flags = 6'b001100;
   bit         m_armed = 1;
   int         m_edges = 0;
   int         cts_hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags = 6'b001100;
         m_armed = 1;
         m_edges = 0;
         cts_hist.delete();
      end else begin
         logic [5:0] o;
         bit cts_ev, idle_ev;
         o = m_flags;
         m_edges++;
         cts_hist.push_back(int'(cts_in));
         // change sampled at edge k reported at edge k+2; quiet for edges 1..3
         cts_ev = (m_edges >= 4) && (cts_hist[m_edges-3] != cts_hist[m_edges-4]);
         idle_ev = ev_idle && m_armed;
         m_flags[0] = cts_ev ? 1'b1 : (wr_clr && clr_data[0]) ? 1'b0 : o[0];
         m_flags[1] = ev_break ? 1'b1 : (wr_clr && clr_data[1]) ? 1'b0 : o[1];
         m_flags[2] = (ev_tx_load || (wr_cmd && cmd_data[0])) ? 1'b1 : wr_tdata ? 1'b0 : o[2];
         m_flags[3] = (ev_tx_frame_done && o[2]) ? 1'b1 : (wr_clr && clr_data[3]) ? 1'b0 : o[3];
         m_flags[4] = ev_rx_char ? 1'b1 : (rd_rdata || (wr_cmd && cmd_data[1])) ? 1'b0 : o[4];
         m_flags[5] = idle_ev ? 1'b1 : (wr_clr && clr_data[5]) ? 1'b0 : o[5];
         if (ev_rx_char) m_armed = 1;
         else if (idle_ev) m_armed = 0;
      end
   end

   function automatic string tag_of(int b);
      case (b)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         for (int b = 0; b < 6; b++)
            chk(flags[b] == m_flags[b], tag_of(b), flags[b], m_flags[b]);
         chk(irq == |(m_flags & irq_en), "R10", irq, |(m_flags & irq_en));
         chk(flags_nb[1] == 1'b0, "R3 absent-break", flags_nb[1], 0);
         chk(flags_nb[5:2] == m_flags[5:2] && flags_nb[0] == m_flags[0],
             "R3 absent-break others", flags_nb, m_flags & 6'b111101);
      end
   end

   task automatic cyc(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic quiet();
      ev_tx_load = 0; ev_tx_frame_done = 0; ev_rx_char = 0; ev_idle = 0; ev_break = 0;
      wr_tdata = 0; rd_rdata = 0; wr_clr = 0; wr_cmd = 0; clr_data = '0; cmd_data = '0;
   endtask

   task automatic do_clr(logic [5:0] w);
      wr_clr = 1; clr_data = w; cyc(); quiet();
   endtask

   initial begin
      #20000000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [5:0] snap;
      cyc(3);
      chk(flags == 6'b001100, "R1 reset value", flags, 6'b001100);
      rst_n = 1;
      cyc(6);
      chk(flags == 6'b001100, "R1 after release", flags, 6'b001100);
      chk(flags[0] == 0, "R2 no change after reset with pin high", flags[0], 0);

      // R2 timing of a synchronized change
      cts_in = 0;
      cyc(2);
      chk(flags[0] == 0, "R2 not before sync delay", flags[0], 0);
      cyc();
      chk(flags[0] == 1, "R2 set after sync delay", flags[0], 1);
      do_clr(6'b000001);
      chk(flags[0] == 0, "R2 cleared", flags[0], 0);

      // R4 transmit buffer empty
      wr_tdata = 1; cyc(); quiet();
      chk(flags[2] == 0, "R4 data write clears", flags[2], 0);
      ev_tx_load = 1; cyc(); quiet();
      chk(flags[2] == 1, "R4 load sets", flags[2], 1);
      wr_tdata = 1; cyc(); quiet();
      wr_cmd = 1; cmd_data = 2'b01; cyc(); quiet();
      chk(flags[2] == 1, "R4 flush sets", flags[2], 1);

      // R5 transmission complete needs TXE
      do_clr(6'b001000);
      chk(flags[3] == 0, "R5 cleared", flags[3], 0);
      wr_tdata = 1; cyc(); quiet();
      ev_tx_frame_done = 1; cyc(); quiet();
      chk(flags[3] == 0, "R5 no set while TXE low", flags[3], 0);
      ev_tx_load = 1; cyc(); quiet();
      ev_tx_frame_done = 1; cyc(); quiet();
      chk(flags[3] == 1, "R5 set with TXE high", flags[3], 1);

      // R6 receive not empty
      ev_rx_char = 1; cyc(); quiet();
      chk(flags[4] == 1, "R6 char sets", flags[4], 1);
      rd_rdata = 1; cyc(); quiet();
      chk(flags[4] == 0, "R6 read clears", flags[4], 0);
      ev_rx_char = 1; cyc(); quiet();
      wr_cmd = 1; cmd_data = 2'b10; cyc(); quiet();
      chk(flags[4] == 0, "R6 flush clears", flags[4], 0);

      // R7 idle re-arm
      ev_idle = 1; cyc(); quiet();
      chk(flags[5] == 1, "R7 idle sets", flags[5], 1);
      do_clr(6'b100000);
      ev_idle = 1; cyc(); quiet();
      chk(flags[5] == 0, "R7 no re-set before new char", flags[5], 0);
      ev_rx_char = 1; cyc(); quiet();
      ev_idle = 1; cyc(); quiet();
      chk(flags[5] == 1, "R7 set after re-arm", flags[5], 1);

      // R8 set wins over clear
      ev_rx_char = 1; rd_rdata = 1; cyc(); quiet();
      chk(flags[4] == 1, "R8 rx set vs read", flags[4], 1);
      ev_break = 1; wr_clr = 1; clr_data = 6'b000010; cyc(); quiet();
      chk(flags[1] == 1, "R8 break set vs clear", flags[1], 1);
      ev_tx_load = 1; wr_tdata = 1; cyc(); quiet();
      chk(flags[2] == 1, "R8 load vs data write", flags[2], 1);

      // R9 zero clear bits
      snap = flags;
      do_clr(6'b000000);
      chk(flags == snap, "R9 zero clear word", flags, snap);
      do_clr(6'b000010);
      chk(flags == (snap & 6'b111101), "R9 only selected bit clears", flags, snap & 6'b111101);

      // R3 break flag and the absent variant
      ev_break = 1; cyc(); quiet();
      chk(flags[1] == 1, "R3 break sets", flags[1], 1);
      chk(flags_nb[1] == 0, "R3 absent break reads 0", flags_nb[1], 0);

      // R10 interrupt gating
      irq_en = 6'b000000; #1;
      chk(irq == 0, "R10 all disabled", irq, 0);
      irq_en = 6'b000010; #1;
      chk(irq == 1, "R10 enabled set flag", irq, 1);
      chk(irq_nb == 0, "R10 absent break no irq", irq_nb, 0);
      irq_en = 6'b000001; #1;
      chk(irq == flags[0], "R10 enabled clear flag", irq, flags[0]);
      cyc();

      // random overlap phase
      for (int k = 0; k < 3000; k++) begin
         ev_tx_load       = ($urandom_range(7) == 0);
         ev_tx_frame_done = ($urandom_range(5) == 0);
         ev_rx_char       = ($urandom_range(7) == 0);
         ev_idle          = ($urandom_range(5) == 0);
         ev_break         = ($urandom_range(9) == 0);
         wr_tdata         = ($urandom_range(7) == 0);
         rd_rdata         = ($urandom_range(7) == 0);
         wr_clr           = ($urandom_range(4) == 0);
         clr_data         = 6'($urandom);
         wr_cmd           = ($urandom_range(9) == 0);
         cmd_data         = 2'($urandom);
         if ($urandom_range(15) == 0) cts_in = ~cts_in;
         if ($urandom_range(31) == 0) irq_en = 6'($urandom);
         cyc();
      end
      quiet();
      cyc(4);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule